// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept and how it is classed. The frame header arrives as a byte stream. The first six bytes are the destination address, sent most significant byte first. The frame length, four mode bits and a table of station addresses are plain inputs. Once the sixth destination byte is taken, the block makes one decision: keep or drop, plus a two-bit class code.

The rules are tried in a fixed priority. A short frame is decided only by the short-frame bit. Next comes promiscuous acceptance of unicast frames, then acceptance of every multicast frame, then the broadcast address. The last rule is an exact match against any enabled entry of a table with `ENTRIES` addresses. The table and its enable mask come from outside the block and are read during the decision cycle. Buffer writing and checksum handling belong to other blocks.

The byte input is a valid/ready stream whose ready is held high. The filter never applies back-pressure, so a byte is taken in every cycle that `in_valid` is high. `frame_len`, the mode bits, `tbl_addr` and `tbl_en` must be stable in the cycle in which the sixth destination byte is taken.

Top module: `rx_addr_filter`

## Requirements
- R1: `in_ready` is always 1. A byte with `in_sof`=1 starts a new destination address, even in the middle of a frame. In the clock after the sixth byte of an address is taken, `dec_valid` is 1 for exactly one cycle. Bytes after the sixth produce no further decision until the next `in_sof`. Gaps with `in_valid`=0 are allowed.
- R2: A frame with `frame_len` below `MIN_LEN` (60, a length that excludes the checksum) is kept only if `cfg_runt_ok`=1, with `dec_type`=00. The address is not looked at. A length of exactly 60 is not short.
- R3: With `cfg_promisc`=1, a frame whose first destination byte has bit 0 clear is kept with `dec_type`=00.
- R4: With `cfg_all_mcast`=1, a frame whose first destination byte has bit 0 set is kept with `dec_type`=01 (bit 0 marks multicast). This also applies to the broadcast address, because this rule comes before the broadcast rule.
- R5: With `cfg_bcast_en`=1, and when R4 does not apply, a destination of six 0xFF bytes is kept with `dec_type`=10 (bit 1 marks broadcast).
- R6: Otherwise a frame is kept with `dec_type`=00 when its destination equals an entry i of the table whose `tbl_en[i]` is 1. Entry i sits at `tbl_addr[48*i+47 : 48*i]`, and the first destination byte is compared with bits 47:40 of the entry. An entry whose enable bit is 0 never matches.
- R7: A frame that none of R2–R6 keeps is dropped, with `dec_accept`=0 and `dec_type`=00.
- R8: After reset, `dec_valid`, `dec_accept` and `dec_type` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header byte valid |
| in_ready | output | 1 | Always 1; the filter never stalls |
| in_sof | input | 1 | Byte is the first destination byte |
| in_data | input | 8 | Header byte |
| frame_len | input | LEN_W | Frame length in bytes, without the checksum |
| cfg_runt_ok | input | 1 | Keep frames shorter than MIN_LEN |
| cfg_promisc | input | 1 | Keep all unicast frames |
| cfg_all_mcast | input | 1 | Keep all multicast frames |
| cfg_bcast_en | input | 1 | Keep broadcast frames |
| tbl_addr | input | 48*ENTRIES | Station address table |
| tbl_en | input | ENTRIES | Per-entry enable mask |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | 1 = keep the frame |
| dec_type | output | 2 | Bit 0 multicast, bit 1 broadcast |

## Verification
Directed frames separate the priority levels from one another:
- A short frame that carries a table address shows that length wins over the address.
- A broadcast sent with both multicast and broadcast modes on shows that the multicast class wins over the broadcast class.
- The same table address sent with its enable bit set and then cleared isolates the enable mask.
- Entries 0 and 15 are used to catch slicing errors at the ends of the table.

Stream patterns check the decision timing: idle gaps inside the address, trailing payload bytes, and a start marker in the middle of an address. A long random run mixes modes, lengths, table hits and special addresses against a per-cycle model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int TYPE_W   = 2;
  localparam int TYPE_MC  = 0;
  localparam int TYPE_BC  = 1;

  typedef struct packed {
    logic              keep;
    logic [TYPE_W-1:0] kind;
  } verdict_t;
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [7:0]              in_data,
  output logic [8*ADDR_BYTES-1:0] addr_view,
  output logic                    addr_done
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] fill;
  logic [7:0]    held [ADDR_BYTES-1];

  // fill == ADDR_BYTES means idle: waiting for a start marker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= CW'(ADDR_BYTES);
    end else if (in_valid) begin
      if (in_sof)
        fill <= CW'(1);
      else if (fill < CW'(ADDR_BYTES))
        fill <= fill + CW'(1);
    end
  end

  for (genvar g = 0; g < ADDR_BYTES - 1; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (in_valid && ((in_sof && g == 0) || (!in_sof && fill == CW'(g))))
        held[g] <= in_data;
    end
    assign addr_view[8*(ADDR_BYTES-1-g) +: 8] = held[g];
  end

  // the final byte is used straight from the input on its arrival cycle
  assign addr_view[7:0] = in_data;
  assign addr_done      = in_valid && !in_sof && (fill == CW'(ADDR_BYTES - 1));
endmodule

// File: rtl/rxf_table_match.sv
module rxf_table_match #(
  parameter int ENTRIES = 16,
  parameter int AW      = 48
) (
  input  logic [AW-1:0]         addr,
  input  logic [ENTRIES*AW-1:0] table_flat,
  input  logic [ENTRIES-1:0]    table_en,
  output logic                  hit
);
  logic [ENTRIES-1:0] eq;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign eq[i] = table_en[i] && (table_flat[AW*i +: AW] == addr);
  end

  assign hit = |eq;
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int AW      = 48,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic [AW-1:0]    addr,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             runt_ok,
  input  logic             promisc,
  input  logic             all_mcast,
  input  logic             bcast_en,
  input  logic             table_hit,
  output verdict_t         verdict
);
  logic group_bit;
  logic is_bcast;
  logic is_short;

  assign group_bit = addr[AW-8];
  assign is_bcast  = &addr;
  assign is_short  = frame_len < LEN_W'(MIN_LEN);

  always_comb begin
    verdict = '0;
    if (is_short) begin
      verdict.keep = runt_ok;
    end else if (promisc && !group_bit) begin
      verdict.keep = 1'b1;
    end else if (all_mcast && group_bit) begin
      verdict.keep         = 1'b1;
      verdict.kind[TYPE_MC] = 1'b1;
    end else if (bcast_en && is_bcast) begin
      verdict.keep         = 1'b1;
      verdict.kind[TYPE_BC] = 1'b1;
    end else if (table_hit) begin
      verdict.keep = 1'b1;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 60
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic                               in_sof,
  input  logic [7:0]                         in_data,
  input  logic [LEN_W-1:0]                   frame_len,
  input  logic                               cfg_runt_ok,
  input  logic                               cfg_promisc,
  input  logic                               cfg_all_mcast,
  input  logic                               cfg_bcast_en,
  input  logic [ENTRIES*8*ADDR_BYTES-1:0]    tbl_addr,
  input  logic [ENTRIES-1:0]                 tbl_en,
  output logic                               dec_valid,
  output logic                               dec_accept,
  output logic [TYPE_W-1:0]                  dec_type
);
  localparam int AW = 8 * ADDR_BYTES;

  logic [AW-1:0] addr_view;
  logic          addr_done;
  logic          table_hit;
  verdict_t      verdict;

  assign in_ready = 1'b1;

  rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .addr_view (addr_view),
    .addr_done (addr_done)
  );

  rxf_table_match #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
    .addr       (addr_view),
    .table_flat (tbl_addr),
    .table_en   (tbl_en),
    .hit        (table_hit)
  );

  rxf_classify #(.AW(AW), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_classify (
    .addr      (addr_view),
    .frame_len (frame_len),
    .runt_ok   (cfg_runt_ok),
    .promisc   (cfg_promisc),
    .all_mcast (cfg_all_mcast),
    .bcast_en  (cfg_bcast_en),
    .table_hit (table_hit),
    .verdict   (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_type   <= '0;
    end else begin
      dec_valid <= addr_done;
      if (addr_done) begin
        dec_accept <= verdict.keep;
        dec_type   <= verdict.kind;
      end
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic [LEN_W-1:0] frame_len,
  input logic             cfg_runt_ok,
  input logic             cfg_all_mcast,
  input logic             cfg_bcast_en,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [1:0]       dec_type
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] seen;
  logic          last_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)
      seen <= CW'(ADDR_BYTES);
    else if (in_valid && in_sof)
      seen <= CW'(1);
    else if (in_valid && seen != CW'(ADDR_BYTES))
      seen <= seen + CW'(1);
  end

  assign last_fire = in_valid && !in_sof && (seen == CW'(ADDR_BYTES - 1));

  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> dec_valid);
  p_strobe_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(last_fire));
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_short_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire && (frame_len < LEN_W'(MIN_LEN)) && !cfg_runt_ok |=> !dec_accept);
  p_class_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_type));
  p_mcast_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_type[0] |-> $past(cfg_all_mcast));
  p_bcast_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_type[1] |-> $past(cfg_bcast_en && !cfg_all_mcast));
  p_drop_no_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_accept |-> dec_type == 2'b00);
endmodule

bind rx_addr_filter rxf_checker #(
  .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
) i_rxf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_sof        (in_sof),
  .frame_len     (frame_len),
  .cfg_runt_ok   (cfg_runt_ok),
  .cfg_all_mcast (cfg_all_mcast),
  .cfg_bcast_en  (cfg_bcast_en),
  .dec_valid     (dec_valid),
  .dec_accept    (dec_accept),
  .dec_type      (dec_type)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int WDOG       = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_sof = 1'b0;
  logic [7:0]    in_data = '0;
  logic [15:0]   frame_len = 16'd100;
  logic          cfg_runt_ok = 1'b0;
  logic          cfg_promisc = 1'b0;
  logic          cfg_all_mcast = 1'b0;
  logic          cfg_bcast_en = 1'b0;
  logic [N*48-1:0] tbl_addr;
  logic [N-1:0]  tbl_en = '0;
  logic          dec_valid;
  logic          dec_accept;
  logic [1:0]    dec_type;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .frame_len(frame_len),
    .cfg_runt_ok(cfg_runt_ok), .cfg_promisc(cfg_promisc),
    .cfg_all_mcast(cfg_all_mcast), .cfg_bcast_en(cfg_bcast_en),
    .tbl_addr(tbl_addr), .tbl_en(tbl_en),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_type(dec_type));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_pos = 6;
  logic [7:0] m_b [6];
  bit         exp_valid = 0;
  bit         exp_acc = 0;
  logic [1:0] exp_type = 0;
  string      exp_tag = "R7";

  task automatic judge(input logic [47:0] da);
    exp_acc = 0; exp_type = 2'b00; exp_tag = "R7";
    if (frame_len < 60) begin
      exp_acc = cfg_runt_ok; exp_tag = "R2";
    end else if (cfg_promisc && da[40] == 1'b0) begin
      exp_acc = 1; exp_tag = "R3";
    end else if (cfg_all_mcast && da[40] == 1'b1) begin
      exp_acc = 1; exp_type = 2'b01; exp_tag = "R4";
    end else if (cfg_bcast_en && da == 48'hFFFF_FFFF_FFFF) begin
      exp_acc = 1; exp_type = 2'b10; exp_tag = "R5";
    end else begin
      for (int i = 0; i < N; i++)
        if (tbl_en[i] && tbl_addr[48*i +: 48] == da) begin
          exp_acc = 1; exp_tag = "R6";
        end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 6; exp_valid = 0; exp_acc = 0; exp_type = 0;
    end else begin
      exp_valid = 0;
      if (in_valid) begin
        if (in_sof) begin
          m_b[0] = in_data; m_pos = 1;
        end else if (m_pos < 6) begin
          m_b[m_pos] = in_data; m_pos++;
          if (m_pos == 6) begin
            judge({m_b[0], m_b[1], m_b[2], m_b[3], m_b[4], m_b[5]});
            exp_valid = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 ready", in_ready, 1'b1);
      chk("R1 strobe", dec_valid, exp_valid);
      if (exp_valid) begin
        chk({exp_tag, " accept"}, dec_accept, exp_acc);
        chk({exp_tag, " type"}, dec_type, exp_type);
      end
    end
  end

  task automatic finish_run;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual %0d expected %0d", cycles, WDOG);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input bit sof, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_data = 8'($urandom);
    end
  endtask

  task automatic frame(input logic [47:0] da, input int len, input int extra, input bit gaps);
    frame_len = 16'(len);
    for (int k = 0; k < 6 + extra; k++) begin
      put(k == 0, k < 6 ? da[47-8*k -: 8] : 8'($urandom));
      if (gaps) idle(1);
    end
    idle(3);
  endtask

  task automatic mode(input bit r, input bit p, input bit m, input bit b);
    cfg_runt_ok = r; cfg_promisc = p; cfg_all_mcast = m; cfg_bcast_en = b;
  endtask

  function automatic logic [47:0] entry(input int i);
    return tbl_addr[48*i +: 48];
  endfunction

  initial begin
    for (int i = 0; i < N; i++)
      tbl_addr[48*i +: 48] = {(i == 3) ? 8'h01 : 8'h02, 8'h1B, 8'h21, 8'h40, 8'(i * 17), 8'(i)};
    tbl_en = 16'b1000_0000_0000_1001;
    repeat (3) @(negedge clk);
    chk("R8 valid", dec_valid, 1'b0);
    chk("R8 accept", dec_accept, 1'b0);
    chk("R8 type", dec_type, 2'b00);
    rst_n = 1;
    idle(2);

    // R2: short frames, even with a table address
    mode(0, 1, 1, 1); frame(entry(0), 59, 0, 0);   // R2 drop
    mode(1, 0, 0, 0); frame(48'h0A0B0C0D0E0F, 20, 0, 0); // R2 keep
    mode(0, 0, 0, 0); frame(entry(0), 60, 0, 0);   // R2 boundary -> R6 keep
    // R3 / R7
    mode(0, 1, 0, 0); frame(48'h0A0B0C0D0E0F, 64, 2, 0);
    mode(0, 0, 0, 0); frame(48'h0A0B0C0D0E0F, 64, 0, 0);
    mode(0, 1, 0, 0); frame(48'h0B0B0C0D0E0F, 64, 0, 0);
    // R4 / R5 priority
    mode(0, 0, 1, 1); frame(48'hFFFF_FFFF_FFFF, 80, 0, 0);
    mode(0, 0, 1, 0); frame(48'h0100_5E00_0001, 80, 0, 1);
    mode(0, 0, 0, 1); frame(48'hFFFF_FFFF_FFFF, 80, 0, 0);
    mode(0, 0, 0, 0); frame(48'hFFFF_FFFF_FFFF, 80, 0, 0);
    // R6: table edges and enable mask
    frame(entry(15), 100, 0, 0);
    frame(entry(3), 100, 0, 0);
    frame(entry(5), 100, 0, 0);
    tbl_en[5] = 1; frame(entry(5), 100, 0, 0);
    tbl_en[15] = 0; frame(entry(15), 100, 0, 0);
    frame(entry(0) ^ 48'h1, 100, 0, 0);
    // R1: restart mid address, trailing bytes
    frame_len = 100;
    put(1, 8'h02); put(0, 8'h1B); put(0, 8'h21);
    frame(entry(0), 100, 8, 1);
    put(0, 8'h55); put(0, 8'h66); idle(3);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [47:0] da;
      int sel;
      sel = $urandom_range(0, 5);
      da = {$urandom, $urandom};
      if (sel == 0) da = 48'hFFFF_FFFF_FFFF;
      else if (sel < 3) da = entry($urandom_range(0, N-1));
      tbl_en = 16'($urandom);
      mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      frame(da, $urandom_range(40, 1500), $urandom_range(0, 3), 1'($urandom));
    end
    finish_run();
  end
endmodule